// File: doc/BRIEF.md
# E1 Timeslot Zero Frame Generator

This block produces the timeslot-zero byte of a 2.048 Mbit/s, 32-timeslot PCM frame and shifts it out one bit per bit clock. Frames come in strict pairs. A sync frame carries the seven-bit frame alignment word, and the frame after it carries user bits. In that second frame bit 2 is held high, so the alignment word never appears in it by accident.

Outside timing logic supplies a mask pulse that is high for exactly eight bit clocks and covers timeslot zero of every frame. On the first clock of that pulse the block captures one spare bit for sync frames, a second spare bit for the other frames and six user bits. It then sends the byte first bit first. While the mask is low the serial output rests at 1, so payload logic can merge timeslots 1 to 31 onto the same line. A frame-parity output tells downstream logic whether the frame being sent, or the next one to be sent, is a sync frame.

Top module: `ts0_framer`

## Requirements
- R1: In a sync frame the eight bits sent are, in order: `spare_sync_bit`, then 0, 0, 1, 1, 0, 1, 1.
- R2: In a non-sync frame the eight bits sent are, in order: `spare_alt_bit`, then 1, then `user_bits[5]`, `user_bits[4]`, `user_bits[3]`, `user_bits[2]`, `user_bits[1]`, `user_bits[0]`.
- R3: Sync and non-sync frames strictly alternate from one mask pulse to the next.
- R4: The serial output is registered. Bit k of the slot (k = 1..8) is on `line_bit` during the clock cycle that follows the k-th rising clock edge at which `slot0_mask` is sampled high.
- R5: All parallel inputs are captured only at the first clock edge of the mask pulse. Changes to them during the rest of the pulse do not alter the bits sent.
- R6: In every cycle after an edge at which `slot0_mask` was sampled low, `line_bit` is 1.
- R7: `sync_phase` is 1 throughout the sending of a sync frame's slot and 0 throughout a non-sync frame's slot. It inverts in the first cycle after the eighth bit, which is the cycle in which `line_bit` returns to idle.
- R8: A synchronous active-high `rst` drives `line_bit` to 1 and `sync_phase` to 1. The first frame after reset is a sync frame, whatever the phase was before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (2.048 MHz in the system) |
| rst | input | 1 | Synchronous reset, active high |
| slot0_mask | input | 1 | High for the eight bit clocks of timeslot zero |
| spare_sync_bit | input | 1 | Bit 1 for sync frames |
| spare_alt_bit | input | 1 | Bit 1 for non-sync frames |
| user_bits | input | 6 | Bits 3 to 8 of non-sync frames, bit 3 at index 5 |
| line_bit | output | 1 | Serial timeslot-zero data, 1 when idle |
| sync_phase | output | 1 | Frame-parity indicator, high for sync frames |

## Verification
The bound checker checks these properties on every clock: the idle level after a low mask, the absence of any `sync_phase` change except right after a mask falls, the value of bit 1 against the spare bit that was captured, and the value of bit 2 for each frame type. The full alignment word, the order of the user bits, the failure to pick up input changes made during the pulse, strict alternation over many frames and recovery from a reset in mid-sequence all depend on values carried across several cycles or several frames. Only the bench's reference model and scenarios can show those.

// File: rtl/ts0_pkg.sv
package ts0_pkg;
   localparam int SLOT_BITS = 8;
   localparam int USER_BITS = 6;
   localparam int FAW_BITS  = SLOT_BITS - 1;

   typedef logic [SLOT_BITS-1:0] slot_t;
   typedef logic [USER_BITS-1:0] user_t;
   typedef logic [FAW_BITS-1:0]  faw_t;

   localparam faw_t FAW_DEFAULT = 7'b0011011;
endpackage

// File: rtl/ts0_word_build.sv
module ts0_word_build
   import ts0_pkg::*;
#(
   parameter faw_t FAW_WORD   = FAW_DEFAULT,
   parameter logic GUARD_BIT  = 1'b1
) (
   input  logic  is_sync,
   input  logic  spare_sync,
   input  logic  spare_alt,
   input  user_t user,
   output slot_t word
);
   slot_t sync_word;
   slot_t alt_word;

   assign sync_word = {spare_sync, FAW_WORD};

   assign alt_word[SLOT_BITS-1] = spare_alt;
   assign alt_word[SLOT_BITS-2] = GUARD_BIT;
   for (genvar gi = 0; gi < USER_BITS; gi++) begin : g_user
      assign alt_word[gi] = user[gi];
   end

   assign word = is_sync ? sync_word : alt_word;
endmodule

// File: rtl/ts0_frame_phase.sv
module ts0_frame_phase #(
   parameter logic RESET_PHASE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic mask,
   output logic slot_start,
   output logic phase
);
   logic mask_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         mask_q <= 1'b0;
         phase  <= RESET_PHASE;
      end else begin
         mask_q <= mask;
         if (mask_q && !mask) phase <= ~phase;
      end
   end

   assign slot_start = mask && !mask_q;
endmodule

// File: rtl/ts0_serializer.sv
module ts0_serializer
   import ts0_pkg::*;
#(
   parameter logic IDLE_LEVEL = 1'b1
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  load,
   input  logic  mask,
   input  slot_t word,
   output logic  serial
);
   localparam slot_t IDLE_FILL = {SLOT_BITS{IDLE_LEVEL}};
   slot_t shreg;

   always_ff @(posedge clk) begin
      if (rst) begin
         serial <= IDLE_LEVEL;
         shreg  <= IDLE_FILL;
      end else if (load) begin
         serial <= word[SLOT_BITS-1];
         shreg  <= {word[SLOT_BITS-2:0], IDLE_LEVEL};
      end else if (mask) begin
         serial <= shreg[SLOT_BITS-1];
         shreg  <= {shreg[SLOT_BITS-2:0], IDLE_LEVEL};
      end else begin
         serial <= IDLE_LEVEL;
         shreg  <= IDLE_FILL;
      end
   end
endmodule

// File: rtl/ts0_framer.sv
module ts0_framer
   import ts0_pkg::*;
#(
   parameter faw_t FAW_WORD    = FAW_DEFAULT,
   parameter logic IDLE_LEVEL  = 1'b1,
   parameter logic GUARD_BIT   = 1'b1,
   parameter logic RESET_PHASE = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       slot0_mask,
   input  logic       spare_sync_bit,
   input  logic       spare_alt_bit,
   input  logic [5:0] user_bits,
   output logic       line_bit,
   output logic       sync_phase
);
   if (FAW_WORD[FAW_BITS-1] == GUARD_BIT) begin : g_bad_guard
      $error("guard bit must differ from the first bit of the alignment word");
   end
   if (USER_BITS + 2 != SLOT_BITS) begin : g_bad_width
      $error("user field width does not fill the slot");
   end

   logic  slot_start;
   slot_t word;

   ts0_frame_phase #(.RESET_PHASE(RESET_PHASE)) u_phase (
      .clk        (clk),
      .rst        (rst),
      .mask       (slot0_mask),
      .slot_start (slot_start),
      .phase      (sync_phase)
   );

   ts0_word_build #(.FAW_WORD(FAW_WORD), .GUARD_BIT(GUARD_BIT)) u_build (
      .is_sync    (sync_phase),
      .spare_sync (spare_sync_bit),
      .spare_alt  (spare_alt_bit),
      .user       (user_bits),
      .word       (word)
   );

   ts0_serializer #(.IDLE_LEVEL(IDLE_LEVEL)) u_ser (
      .clk    (clk),
      .rst    (rst),
      .load   (slot_start),
      .mask   (slot0_mask),
      .word   (word),
      .serial (line_bit)
   );
endmodule

// File: rtl/ts0_framer_chk.sv
module ts0_framer_chk (
   input logic clk,
   input logic rst,
   input logic slot0_mask,
   input logic spare_sync_bit,
   input logic spare_alt_bit,
   input logic line_bit,
   input logic sync_phase
);
   // R6: idle level after a low mask
   p_idle_r6: assert property (@(posedge clk) disable iff (rst)
      !$past(slot0_mask) |-> line_bit);

   // R7: the phase only moves right after the mask falls
   p_phase_move_r7: assert property (@(posedge clk) disable iff (rst)
      (sync_phase != $past(sync_phase)) |-> ($past(slot0_mask, 2) && !$past(slot0_mask)));

   // R1 and R2: bit 1 comes from the spare input that matches the frame type
   p_first_bit_r1: assert property (@(posedge clk) disable iff (rst)
      ($past(slot0_mask) && !$past(slot0_mask, 2)) |->
      (line_bit == (sync_phase ? $past(spare_sync_bit) : $past(spare_alt_bit))));

   // R1: bit 2 of a sync frame is 0
   p_sync_bit2_r1: assert property (@(posedge clk) disable iff (rst)
      (sync_phase && $past(slot0_mask) && $past(slot0_mask, 2) && !$past(slot0_mask, 3))
      |-> !line_bit);

   // R2: bit 2 of a non-sync frame is 1
   p_guard_bit2_r2: assert property (@(posedge clk) disable iff (rst)
      (!sync_phase && $past(slot0_mask) && $past(slot0_mask, 2) && !$past(slot0_mask, 3))
      |-> line_bit);
endmodule

bind ts0_framer ts0_framer_chk u_chk (
   .clk            (clk),
   .rst            (rst),
   .slot0_mask     (slot0_mask),
   .spare_sync_bit (spare_sync_bit),
   .spare_alt_bit  (spare_alt_bit),
   .line_bit       (line_bit),
   .sync_phase     (sync_phase)
);

// File: tb/ts0_framer_tb.sv
module ts0_framer_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       slot0_mask = 1'b0;
   logic       spare_sync_bit = 1'b0;
   logic       spare_alt_bit = 1'b0;
   logic [5:0] user_bits = 6'd0;
   logic       line_bit;
   logic       sync_phase;

   int tests = 0;
   int fails = 0;

   // reference model state
   bit    q[$];
   bit    exp_line = 1'b1;
   bit    exp_phase = 1'b1;
   bit    prev_mask = 1'b0;
   string kind = "R8";
   string scen = "";
   int    last_ts0_phase = -1;

   always #2.5 clk = ~clk;

   ts0_framer u_dut (
      .clk            (clk),
      .rst            (rst),
      .slot0_mask     (slot0_mask),
      .spare_sync_bit (spare_sync_bit),
      .spare_alt_bit  (spare_alt_bit),
      .user_bits      (user_bits),
      .line_bit       (line_bit),
      .sync_phase     (sync_phase)
   );

   task automatic model_edge();
      if (rst) begin
         q.delete();
         exp_line  = 1'b1;
         exp_phase = 1'b1;
         prev_mask = 1'b0;
         kind      = "R8";
         return;
      end
      if (slot0_mask && !prev_mask) begin
         q.delete();
         if (exp_phase) begin
            q.push_back(spare_sync_bit);
            q.push_back(0); q.push_back(0); q.push_back(1);
            q.push_back(1); q.push_back(0); q.push_back(1); q.push_back(1);
         end else begin
            q.push_back(spare_alt_bit);
            q.push_back(1);
            for (int k = 5; k >= 0; k--) q.push_back(user_bits[k]);
         end
      end
      if (slot0_mask && q.size() > 0) begin
         exp_line = q.pop_front();
         kind = exp_phase ? "R1" : "R2";
      end else begin
         q.delete();
         exp_line = 1'b1;
         kind = "R6";
      end
      if (prev_mask && !slot0_mask) exp_phase = !exp_phase;
      prev_mask = slot0_mask;
   endtask

   task automatic check(input string tag, input logic got, input logic exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got %0b expected %0b at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check({kind, " ", scen, " line"}, line_bit, exp_line);
      check({"R7 ", scen, " phase"}, sync_phase, exp_phase);
   endtask

   task automatic send_frame(input logic ss, input logic sa, input logic [5:0] u,
                             input bit wiggle, input int gap);
      spare_sync_bit = ss;
      spare_alt_bit  = sa;
      user_bits      = u;
      slot0_mask     = 1'b1;
      for (int i = 0; i < 8; i++) begin
         cyc();
         if (i == 0) begin
            if (last_ts0_phase >= 0)
               check("R3 alternation", sync_phase, logic'(last_ts0_phase == 0));
            last_ts0_phase = int'(sync_phase);
         end
         if (wiggle) begin
            spare_sync_bit = ~spare_sync_bit;
            spare_alt_bit  = ~spare_alt_bit;
            user_bits      = user_bits ^ 6'(7 * i + 13);
         end
      end
      slot0_mask = 1'b0;
      for (int i = 0; i < gap; i++) cyc();
   endtask

   initial begin
      #(5 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      scen = "R8 reset";
      for (int i = 0; i < 4; i++) cyc();
      rst = 1'b0;
      scen = "R6 idle";
      for (int i = 0; i < 3; i++) cyc();

      scen = "R4 order";
      send_frame(1'b1, 1'b0, 6'b101100, 1'b0, 5);
      send_frame(1'b0, 1'b1, 6'b110010, 1'b0, 5);
      send_frame(1'b0, 1'b0, 6'b000000, 1'b0, 4);
      send_frame(1'b1, 1'b0, 6'b111111, 1'b0, 4);
      send_frame(1'b1, 1'b1, 6'b010101, 1'b0, 3);
      send_frame(1'b0, 1'b0, 6'b100001, 1'b0, 3);

      scen = "R5 capture";
      send_frame(1'b1, 1'b0, 6'b011010, 1'b1, 4);
      send_frame(1'b0, 1'b1, 6'b100110, 1'b1, 4);

      scen = "R3 run";
      for (int f = 0; f < 20; f++)
         send_frame(f[0], f[1], 6'(f * 11 + 5), f[2], 2 + (f % 3));

      scen = "R8 midrun";
      send_frame(1'b1, 1'b0, 6'b001111, 1'b0, 2);
      rst = 1'b1;
      for (int i = 0; i < 3; i++) cyc();
      rst = 1'b0;
      last_ts0_phase = 0;
      cyc();
      send_frame(1'b0, 1'b1, 6'b110011, 1'b0, 4);
      send_frame(1'b1, 1'b0, 6'b001100, 1'b0, 4);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule